// File: doc/BRIEF.md
# Multi-View Pixel Aperture Controller

The block sits between a 32-bit host request port and a synchronous pixel store in which each pixel holds 26 bits. Those bits are 24 colour bits plus a 2-bit per-pixel mode field. The host reaches the same pixel array through three address windows, each with its own read and write rules:

- a full-word view that exposes the mode field;
- a colour-only word view that hides the mode field and protects it from writes;
- a packed byte view in which every byte address is one pixel and only the red plane is touched.

Where a view may change only part of a pixel, the block reads the stored pixel, merges the new bits in and writes the result back. A full-word write with all four byte enables is the one case that needs no read first.

The host port accepts one request at a time with a valid/ready handshake. It returns exactly one response pulse per request, and that pulse carries the read data. The pixel store returns read data one cycle after a read request.

Top module: `fbv_aperture`

## Requirements
- R1: Address bits [PIX_AW+3:PIX_AW+2] select the view: 00 packed byte, 01 colour word, 10 full word. Code 11 is a void window: reads return zero, and no memory access is made for a read or a write.
- R2: A full-view read returns the stored pixel as {6'b0, mode[1:0], colour[23:0]}, so bits 31:26 read as zero.
- R3: On a full-view write, byte enables 0..2 replace colour bytes 0..2, and enable 3 replaces only the mode field from wdata[25:24]; bits 31:26 are ignored. With all four enables set, the write takes exactly one memory access and no read.
- R4: A colour-view read returns {8'h00, colour[23:0]}.
- R5: A colour-view write replaces only the colour bytes whose enables are set (bytes 0..2). Enable 3 and data bits 31:24 have no effect, and the mode field is never changed.
- R6: In the packed view, word offset bits [PIX_AW-1:2] pick four consecutive pixels, and byte lane k maps to pixel {offset[PIX_AW-1:2], k}. In the word views, the pixel index is offset[PIX_AW+1:2].
- R7: A packed-view write of lane k replaces only the red plane (stored bits 7:0) of its pixel with wdata[8k+7:8k]. The other 18 stored bits are kept. Each enabled lane gets its own read-modify-write.
- R8: A packed-view read returns the red plane of the lane-k pixel in byte k for every enabled lane, and zero in disabled lanes. Disabled lanes cause no memory access.
- R9: req_ready_o is low from the cycle after an accepted request until that request's single one-cycle response pulse. Write responses carry zero data.
- R10: During reset, req_ready_o is high, and rsp_valid_o and mem_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | PIX_AW+4 | Byte address: window code in the top two bits, offset below |
| req_be_i | input | 4 | Byte enables |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_rdata_o | output | 32 | Read data, valid with rsp_valid_o |
| mem_req_o | output | 1 | Pixel store access |
| mem_we_o | output | 1 | Pixel store write |
| mem_addr_o | output | PIX_AW | Pixel index |
| mem_wdata_o | output | 26 | Pixel write data |
| mem_rdata_i | input | 26 | Pixel read data, one cycle after a read access |

## Verification
Pixels are first loaded through the full view with set mode bits and junk in bits 31:26. Reads through all three views then tell apart the masking each view applies. Partial byte enables in the colour and full views separate colour updates from mode updates. A colour write with enable 3 set shows that the mode field survives. A four-lane packed write followed by full-view readback reveals any lane-to-pixel swap or lost upper bits, and sparse-lane packed reads expose memory accesses made for disabled lanes. Void accesses, the access count of a fast full write and of a colour write, and the response count close the set.

// File: rtl/fbv_pkg.sv
package fbv_pkg;
  localparam int PIX_W  = 26;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    WIN_P8   = 2'b00,
    WIN_C24  = 2'b01,
    WIN_FULL = 2'b10,
    WIN_VOID = 2'b11
  } win_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_MRG,
    ST_WR,
    ST_DONE
  } st_e;
endpackage

// File: rtl/fbv_win_decode.sv
module fbv_win_decode
  import fbv_pkg::*;
#(
  parameter int PIX_AW = 10,
  localparam int ADDR_W = PIX_AW + 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic              we_i,
  output win_e              win_o,
  output logic [PIX_AW-1:0] pix_base_o,
  output logic [LANES-1:0]  lanes_o,
  output logic              fast_wr_o
);
  logic unused_lsb;
  assign unused_lsb = ^addr_i[1:0];

  always_comb begin
    win_o      = win_e'(addr_i[ADDR_W-1:ADDR_W-2]);
    pix_base_o = addr_i[PIX_AW+1:2];
    lanes_o    = '0;
    unique case (win_o)
      WIN_P8: begin
        pix_base_o = {addr_i[PIX_AW-1:2], 2'b00};
        lanes_o    = be_i;
      end
      WIN_C24, WIN_FULL: lanes_o = (we_i && be_i == '0) ? '0 : LANES'(1);
      default: lanes_o = '0;
    endcase
    fast_wr_o = we_i && (win_o == WIN_FULL) && (be_i == '1);
  end
endmodule

// File: rtl/fbv_lane_pick.sv
module fbv_lane_pick
  import fbv_pkg::*;
#(
  localparam int LW = $clog2(LANES)
) (
  input  logic [LANES-1:0] pend_i,
  output logic [LW-1:0]    lane_o,
  output logic [LANES-1:0] rest_o
);
  // lowest pending lane first
  always_comb begin
    lane_o = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (pend_i[k]) lane_o = LW'(k);
    end
    rest_o = pend_i & ~(LANES'(1) << lane_o);
  end
endmodule

// File: rtl/fbv_pix_merge.sv
module fbv_pix_merge
  import fbv_pkg::*;
#(
  localparam int LW = $clog2(LANES)
) (
  input  win_e              win_i,
  input  logic [LW-1:0]     lane_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PIX_W-1:0]  old_i,
  output logic [PIX_W-1:0]  new_o,
  output logic [DATA_W-1:0] rd_o
);
  always_comb begin
    new_o = old_i;
    rd_o  = '0;
    unique case (win_i)
      WIN_FULL: begin
        for (int b = 0; b < 3; b++) if (be_i[b]) new_o[8*b +: 8] = wdata_i[8*b +: 8];
        if (be_i[3]) new_o[25:24] = wdata_i[25:24];
        rd_o = DATA_W'(old_i);
      end
      WIN_C24: begin
        for (int b = 0; b < 3; b++) if (be_i[b]) new_o[8*b +: 8] = wdata_i[8*b +: 8];
        rd_o = {8'h00, old_i[23:0]};
      end
      WIN_P8: begin
        new_o[7:0] = wdata_i[8*lane_i +: 8];
        rd_o       = DATA_W'(old_i[7:0]) << (8 * lane_i);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fbv_aperture.sv
module fbv_aperture
  import fbv_pkg::*;
#(
  parameter int PIX_AW = 10,
  localparam int ADDR_W = PIX_AW + 4,
  localparam int LW = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LANES-1:0]  req_be_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [PIX_AW-1:0] mem_addr_o,
  output logic [PIX_W-1:0]  mem_wdata_o,
  input  logic [PIX_W-1:0]  mem_rdata_i
);
  st_e               st_q;
  win_e              win_q, dec_win;
  logic              we_q;
  logic [LANES-1:0]  be_q, pend_q, dec_lanes, rest;
  logic [DATA_W-1:0] wdata_q, rdata_q, rd_word;
  logic [PIX_AW-1:0] base_q, dec_base, cur_addr;
  logic [LW-1:0]     lane;
  logic [PIX_W-1:0]  merged;
  logic              dec_fast;

  fbv_win_decode #(.PIX_AW(PIX_AW)) i_dec (
    .addr_i(req_addr_i), .be_i(req_be_i), .we_i(req_we_i),
    .win_o(dec_win), .pix_base_o(dec_base), .lanes_o(dec_lanes), .fast_wr_o(dec_fast)
  );

  fbv_lane_pick i_pick (.pend_i(pend_q), .lane_o(lane), .rest_o(rest));

  fbv_pix_merge i_merge (
    .win_i(win_q), .lane_i(lane), .be_i(be_q), .wdata_i(wdata_q),
    .old_i(mem_rdata_i), .new_o(merged), .rd_o(rd_word)
  );

  assign cur_addr = (win_q == WIN_P8) ? {base_q[PIX_AW-1:2], lane} : base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      win_q   <= WIN_VOID;
      we_q    <= 1'b0;
      be_q    <= '0;
      pend_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      base_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          win_q   <= dec_win;
          we_q    <= req_we_i;
          be_q    <= req_be_i;
          wdata_q <= req_wdata_i;
          base_q  <= dec_base;
          pend_q  <= dec_lanes;
          rdata_q <= '0;
          if (dec_fast)              st_q <= ST_WR;
          else if (dec_lanes != '0)  st_q <= ST_RD;
          else                       st_q <= ST_DONE;
        end
        ST_RD: st_q <= ST_MRG;
        ST_MRG: begin
          if (!we_q) rdata_q <= rdata_q | rd_word;
          pend_q <= rest;
          st_q   <= (rest != '0) ? ST_RD : ST_DONE;
        end
        ST_WR:   st_q <= ST_DONE;
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur_addr;
    mem_wdata_o = merged;
    unique case (st_q)
      ST_RD:  mem_req_o = 1'b1;
      ST_MRG: begin
        mem_req_o = we_q;
        mem_we_o  = we_q;
      end
      ST_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = wdata_q[PIX_W-1:0];
      end
      default: ;
    endcase
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign rsp_valid_o = (st_q == ST_DONE);
  assign rsp_rdata_o = rdata_q;

  // R9
  hs_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  // R9
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));
  // R1
  void_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && win_q == WIN_VOID) |-> !mem_req_o);
  // R5
  c24_mode_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && win_q == WIN_C24) |-> (mem_wdata_o[25:24] == mem_rdata_i[25:24]));
  // R7
  p8_plane_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && win_q == WIN_P8) |-> (mem_wdata_o[25:8] == mem_rdata_i[25:8]));
  // R3
  full_mode_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && st_q == ST_MRG && win_q == WIN_FULL && !be_q[3])
      |-> (mem_wdata_o[25:24] == mem_rdata_i[25:24]));
endmodule

// File: tb/test_fbv_aperture.sv
module test_fbv_aperture;
  localparam int PIX_AW = 8;
  localparam int AW = PIX_AW + 4;
  localparam int NPIX = 1 << PIX_AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_be = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_req, mem_we;
  logic [31:0] rsp_rdata;
  logic [PIX_AW-1:0] mem_addr;
  logic [25:0] mem_wdata, mem_rdata;

  logic [25:0] mem [NPIX];
  logic [25:0] sh [NPIX];
  logic [31:0] exp_q[$];
  string tag_q[$];
  int n_chk = 0, n_bad = 0, n_req = 0, n_rsp = 0, n_mem = 0;

  always #4 clk = ~clk;

  fbv_aperture #(.PIX_AW(PIX_AW)) i_fbv_aperture (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  initial for (int i = 0; i < NPIX; i++) begin mem[i] = '0; sh[i] = '0; end

  always @(posedge clk) begin
    if (mem_req) begin
      n_mem <= n_mem + 1;
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else mem_rdata <= mem[mem_addr];
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop and compare each response
  always @(negedge clk) begin
    if (rsp_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R9 unexpected response", rsp_rdata, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_rdata === e, t, rsp_rdata, e);
      end
      n_rsp++;
    end
  end

  function automatic logic [31:0] model_read(logic [1:0] win, int off, logic [3:0] be);
    logic [31:0] r = '0;
    int p = (off >> 2) % NPIX;
    case (win)
      2'b10: r = {6'b0, sh[p]};
      2'b01: r = {8'b0, sh[p][23:0]};
      2'b00: for (int k = 0; k < 4; k++)
               if (be[k]) r[8*k +: 8] = sh[((off >> 2) << 2) % NPIX + k][7:0];
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic void model_write(logic [1:0] win, int off, logic [3:0] be, logic [31:0] d);
    int p = (off >> 2) % NPIX;
    case (win)
      2'b10: begin
        for (int b = 0; b < 3; b++) if (be[b]) sh[p][8*b +: 8] = d[8*b +: 8];
        if (be[3]) sh[p][25:24] = d[25:24];
      end
      2'b01: for (int b = 0; b < 3; b++) if (be[b]) sh[p][8*b +: 8] = d[8*b +: 8];
      2'b00: for (int k = 0; k < 4; k++)
               if (be[k]) sh[((off >> 2) << 2) % NPIX + k][7:0] = d[8*k +: 8];
      default: ;
    endcase
  endfunction

  // driver: push expected item, issue request, wait for its response
  task automatic access(bit we, logic [1:0] win, int off, logic [3:0] be, logic [31:0] d, string tag);
    if (we) begin
      model_write(win, off, be, d);
      exp_q.push_back(32'h0);
    end else exp_q.push_back(model_read(win, off, be));
    tag_q.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = {win, (PIX_AW + 2)'(off)};
    req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    n_req++;
    wait (n_rsp == n_req);
  endtask

  task automatic rd_full(int pix, string tag);
    access(1'b0, 2'b10, pix * 4, 4'hF, 32'h0, tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    summary();
  end

  initial begin
    int m0;
    #3;
    // R10 reset state
    check(req_ready === 1'b1, "R10 ready in reset", 32'(req_ready), 32'h1);
    check(rsp_valid === 1'b0, "R10 rsp in reset", 32'(rsp_valid), 32'h0);
    check(mem_req === 1'b0, "R10 mem_req in reset", 32'(mem_req), 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 fast full write: one memory access
    m0 = n_mem;
    access(1'b1, 2'b10, 4 * 4, 4'hF, 32'hFEAB_CDEF, "R3 full write");
    check(n_mem - m0 == 1, "R3 single access", 32'(n_mem - m0), 32'h1);
    access(1'b1, 2'b10, 5 * 4, 4'hF, 32'h0111_2233, "R3 full write");
    access(1'b1, 2'b10, 6 * 4, 4'hF, 32'hFF44_5566, "R3 full write");
    access(1'b1, 2'b10, 7 * 4, 4'hF, 32'h0277_8899, "R3 full write");
    rd_full(4, "R2 full read masks 31:26");
    rd_full(7, "R2 full read");

    // R4/R5 colour view
    access(1'b0, 2'b01, 4 * 4, 4'hF, 32'h0, "R4 colour read");
    m0 = n_mem;
    access(1'b1, 2'b01, 4 * 4, 4'hF, 32'hFF11_2233, "R5 colour write");
    check(n_mem - m0 == 2, "R5 read-modify-write", 32'(n_mem - m0), 32'h2);
    rd_full(4, "R5 mode kept");
    access(1'b1, 2'b01, 4 * 4, 4'b0010, 32'hAAAA_99AA, "R5 partial colour");
    rd_full(4, "R5 only byte1");

    // R3 partial full-view writes
    access(1'b1, 2'b10, 4 * 4, 4'b1000, 32'hFD00_0000, "R3 mode only");
    rd_full(4, "R3 mode only readback");
    access(1'b1, 2'b10, 4 * 4, 4'b0001, 32'h0303_0355, "R3 byte0 only");
    rd_full(4, "R3 byte0 readback");

    // R6/R7 packed view
    access(1'b1, 2'b00, 4, 4'hF, 32'hA1B2_C3D4, "R7 packed write");
    rd_full(4, "R6 lane0 pixel");
    rd_full(5, "R6 lane1 pixel");
    rd_full(6, "R7 upper bits kept");
    rd_full(7, "R7 lane3 pixel");
    access(1'b1, 2'b00, 4, 4'b0100, 32'h55EE_5555, "R7 single lane");
    rd_full(6, "R7 single lane readback");
    rd_full(5, "R7 other lane untouched");

    // R8 packed read, sparse lanes
    m0 = n_mem;
    access(1'b0, 2'b00, 4, 4'b1010, 32'h0, "R8 sparse packed read");
    check(n_mem - m0 == 2, "R8 disabled lanes no access", 32'(n_mem - m0), 32'h2);
    access(1'b0, 2'b00, 4, 4'hF, 32'h0, "R8 full packed read");

    // R1 void window
    m0 = n_mem;
    access(1'b1, 2'b11, 4 * 4, 4'hF, 32'hFFFF_FFFF, "R1 void write");
    access(1'b0, 2'b11, 4 * 4, 4'hF, 32'h0, "R1 void read");
    check(n_mem - m0 == 0, "R1 void no access", 32'(n_mem - m0), 32'h0);
    rd_full(4, "R1 pixel unchanged");

    // R9 handshake bookkeeping
    repeat (3) @(negedge clk);
    check(n_rsp == n_req, "R9 one response per request", 32'(n_rsp), 32'(n_req));
    check(exp_q.size() == 0, "R9 no pending", 32'(exp_q.size()), 32'h0);
    check(req_ready === 1'b1 && rsp_valid === 1'b0, "R9 idle", 32'(req_ready), 32'h1);
    summary();
  end
endmodule